// File: doc/BRIEF.md
# Sampled Reuse-Distance Monitor

This block watches a stream of memory write line addresses and estimates how many writes typically pass between two writes to the same line. Ordinary traffic seldom reuses a line within a short span. A stream that keeps hammering a few lines reuses them often. A small wear-levelling controller uses the estimate to decide how aggressively to relocate lines.

A short fully associative recency stack holds a handful of sampled addresses. Every write is looked up. A match moves the entry to the most-recent slot and counts as a hit. A miss enters the stack only when an internal pseudo-random generator allows it, which happens about once in 256 misses, so a stack of a few entries still covers a window of roughly a thousand writes. Two saturating-range counters gather hits and writes. When the write counter fills, the block divides writes by hits in the background and publishes the quotient as the distance estimate. It then halves both counters, so older history fades gradually and is not discarded.

Top module: `reuse_dist_monitor`

## Requirements
- R1: While rst_n is low, and after reset until the first estimate, dist_q holds the all-ones value (65535 at the default 16-bit width), meaning no reuse seen.
- R2: A cycle with wr_valid low changes no counter, no stack entry and no generator state, whatever wr_addr carries.
- R3: A write whose address equals a valid stack entry is a hit: the hit counter increments and that entry moves to the most-recent slot, with the entries that were more recent each moving one slot older. Entries cleared by reset are invalid and never hit, even for address zero.
- R4: On a miss, the address is placed in the most-recent slot and the oldest entry is dropped only when bits [7:0] of a 16-bit generator are all zero; otherwise the stack is unchanged. The generator resets to 16'hACE1 and advances once per write as next = {g[14:0], g[15]^g[13]^g[12]^g[10]}, the decision using the value before the advance.
- R5: On the write that brings the write counter to its all-ones value, the estimate becomes floor(all_ones / hits), where hits includes that write's own hit.
- R6: If that hit total is zero, dist_q becomes all-ones on the very next clock edge.
- R7: At that same write, the write counter is set to all_ones>>1 and the hit counter to floor(hits/2); the next estimate therefore follows 2^(W-1) further writes, W being the counter width.
- R8: dist_q changes only when an estimate completes; a non-zero hit total yields the new value exactly W clock edges after the edge that sampled the triggering write.
- R9: The hit counter never exceeds the write counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write address is presented this cycle |
| wr_addr | input | ADDR_W | Line address of the write |
| dist_q | output | CNT_W | Latest reuse-distance estimate |

## Verification
The checker watches every cycle for counter bookkeeping: idle cycles leave both counters alone, each write advances the write counter, an estimate halves both counters, a zero hit total saturates the output at once, the output never moves without an estimate in progress, and hits never outnumber writes. Which address hits, how the recency order shifts, when the generator allows an insertion and the exact quotient can only be shown by the bench's scenarios. There a reference model of the stack and generator predicts each estimate for repeat-one-line, short cyclic, stack-sized, over-sized and non-repeating streams, and the result latency is timed edge by edge.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int unsigned RNG_W    = 16;
  localparam int unsigned SAMPLE_W = 8;
  localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

  // Fibonacci step, taps 16,14,13,11
  function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
    return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/rdm_rng.sv
module rdm_rng
  import rdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic sample
);
  logic [RNG_W-1:0] st_q, st_d;

  always_comb begin
    st_d = adv ? rng_next(st_q) : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RNG_SEED;
    else if (adv) st_q <= st_d;
  end

  assign sample = (st_q[SAMPLE_W-1:0] == '0);
endmodule

// File: rtl/rdm_lru.sv
module rdm_lru #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_valid,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              insert_ok,
  output logic              hit
);
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0]             val_q, val_d;
  int unsigned                    hidx, lim;
  logic                           move;

  always_comb begin
    hit  = 1'b0;
    hidx = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && val_q[i] && tag_q[i] == look_addr) begin
        hit  = 1'b1;
        hidx = i;
      end
    end
    move  = look_valid && (hit || insert_ok);
    lim   = hit ? hidx : ENTRIES - 1;
    tag_d = tag_q;
    val_d = val_q;
    if (move) begin
      for (int i = ENTRIES - 1; i > 0; i--) begin
        if (i <= lim) begin
          tag_d[i] = tag_q[i-1];
          val_d[i] = val_q[i-1];
        end
      end
      tag_d[0] = look_addr;
      val_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (move) begin
      tag_q <= tag_d;
      val_q <= val_d;
    end
  end
endmodule

// File: rtl/rdm_div.sv
module rdm_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int unsigned CNT_B = $clog2(W + 1);

  logic             busy_q;
  logic [CNT_B-1:0] cnt_q;
  logic [W-1:0]     rem_q, quo_q, den_q;
  logic [W:0]       trial, rem_n;
  logic [W-1:0]     quo_n;
  logic             ge;

  always_comb begin
    trial  = {rem_q, quo_q[W-1]};
    ge     = trial >= {1'b0, den_q};
    rem_n  = ge ? trial - {1'b0, den_q} : trial;
    quo_n  = {quo_q[W-2:0], ge};
    done   = busy_q && (cnt_q == CNT_B'(W - 1));
    result = quo_n;
    busy   = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else if (start) begin
      busy_q <= (den != '0);
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= num;
      den_q  <= den;
    end else if (busy_q) begin
      rem_q  <= rem_n[W-1:0];
      quo_q  <= quo_n;
      cnt_q  <= cnt_q + 1'b1;
      busy_q <= !done;
    end
  end
endmodule

// File: rtl/reuse_dist_monitor.sv
module reuse_dist_monitor #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  dist_q
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

  logic             insert_ok, lru_hit, hit_v, eval;
  logic             div_busy, div_done;
  logic [CNT_W-1:0] div_res;
  logic [CNT_W-1:0] wc_q, wc_d, hc_q, hc_d, hc_sum;
  logic [CNT_W-1:0] dist_d;
  logic             dist_en;

  rdm_rng u_rng (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (wr_valid),
    .sample (insert_ok)
  );

  rdm_lru #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_valid (wr_valid),
    .look_addr  (wr_addr),
    .insert_ok  (insert_ok),
    .hit        (lru_hit)
  );

  always_comb begin
    hit_v  = wr_valid && lru_hit;
    hc_sum = hc_q + CNT_W'(hit_v);
    eval   = wr_valid && (wc_q == CNT_LAST);
    wc_d   = wc_q;
    hc_d   = hc_q;
    if (eval) begin
      wc_d = CNT_MAX >> 1;
      hc_d = hc_sum >> 1;
    end else if (wr_valid) begin
      wc_d = wc_q + 1'b1;
      hc_d = hc_sum;
    end
  end

  rdm_div #(.W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eval),
    .num    (CNT_MAX),
    .den    (hc_sum),
    .busy   (div_busy),
    .done   (div_done),
    .result (div_res)
  );

  always_comb begin
    dist_en = 1'b0;
    dist_d  = dist_q;
    if (eval && hc_sum == '0) begin
      dist_en = 1'b1;
      dist_d  = CNT_MAX;
    end else if (div_done) begin
      dist_en = 1'b1;
      dist_d  = div_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q <= '0;
      hc_q <= '0;
    end else if (wr_valid) begin
      wc_q <= wc_d;
      hc_q <= hc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= CNT_MAX;
    else if (dist_en) dist_q <= dist_d;
  end
endmodule

// File: rtl/rdm_check.sv
module rdm_check #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             eval,
  input logic             div_busy,
  input logic [CNT_W-1:0] wc,
  input logic [CNT_W-1:0] hc,
  input logic [CNT_W-1:0] den,
  input logic [CNT_W-1:0] dist_q
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(wc) && $stable(hc))); // R2

  AST_WRITE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !eval) |=> (wc == CNT_W'($past(wc) + 1'b1))); // R2

  AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && den == '0) |=> (dist_q == ALL1)); // R6

  AST_HALVE_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> (wc == (ALL1 >> 1) && hc == ($past(den) >> 1))); // R7

  AST_DIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_busy && !eval) |=> $stable(dist_q)); // R8

  AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hc <= wc); // R9
endmodule

bind reuse_dist_monitor rdm_check #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .eval     (eval),
  .div_busy (div_busy),
  .wc       (wc_q),
  .hc       (hc_q),
  .den      (hc_sum),
  .dist_q   (dist_q)
);

// File: tb/reuse_dist_monitor_tb.sv
module reuse_dist_monitor_tb;
  localparam int AW   = 16;
  localparam int ENT  = 4;
  localparam int CW   = 10;
  localparam int MAXV = (1 << CW) - 1;
  localparam int NV   = 6;
  // stimulus table: base address, repeat period, number of writes
  localparam int V_BASE [NV] = '{'h0200, 'h0300, 'h0400, 'h0500, 'h2000, 'h0600};
  localparam int V_PER  [NV] = '{1, 3, ENT, ENT + 1, 2048, 2};
  localparam int V_LEN  [NV] = '{600, 700, 800, 900, 1100, 512};

  logic          clk, rst_n, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] dist_q;

  int n_run, n_fail, cyc;

  // reference model state
  logic [AW-1:0] m_tag [ENT];
  logic          m_val [ENT];
  logic [15:0]   m_rng;
  int            m_wc, m_hc, m_dist;

  reuse_dist_monitor #(.ADDR_W(AW), .ENTRIES(ENT), .CNT_W(CW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .dist_q   (dist_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) begin
      m_tag[i] = '0;
      m_val[i] = 1'b0;
    end
    m_rng  = 16'hACE1;
    m_wc   = 0;
    m_hc   = 0;
    m_dist = MAXV;
  endtask

  task automatic model_write(input logic [AW-1:0] a);
    bit hit = 0;
    int h   = 0;
    for (int i = 0; i < ENT; i++)
      if (!hit && m_val[i] && m_tag[i] == a) begin hit = 1; h = i; end
    if (hit) begin
      for (int j = h; j > 0; j--) begin m_tag[j] = m_tag[j-1]; m_val[j] = m_val[j-1]; end
      m_tag[0] = a;
      m_hc++;
    end else if (m_rng[7:0] == 8'h00) begin
      for (int j = ENT - 1; j > 0; j--) begin m_tag[j] = m_tag[j-1]; m_val[j] = m_val[j-1]; end
      m_tag[0] = a;
      m_val[0] = 1'b1;
    end
    m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
    if (m_wc == MAXV - 1) begin
      m_dist = (m_hc == 0) ? MAXV : MAXV / m_hc;
      m_wc   = MAXV / 2;
      m_hc   = m_hc / 2;
    end else begin
      m_wc++;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    model_write(a);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    wr_valid = 1'b0;
    wr_addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(dist_q), MAXV);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: no address ever repeats, estimate saturates
    for (int i = 0; i < MAXV; i++) wr(AW'('h1000 + i));
    idle(30);
    check("R6 no reuse saturates", int'(dist_q), MAXV);

    // R3/R8: repeat address zero after reset; invalid entries must not hit;
    // result appears exactly CW edges after the triggering write
    do_reset();
    for (int i = 0; i < MAXV; i++) wr(AW'(0));
    #1 wr_valid = 1'b0;
    repeat (CW - 1) @(posedge clk);
    #1 check("R8 value held before latency", int'(dist_q), MAXV);
    @(posedge clk);
    #1 check("R3 R8 estimate at latency", int'(dist_q), m_dist);
    idle(20);

    // table walk: several reuse patterns, model predicts each estimate
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < V_LEN[v]; i++) wr(AW'(V_BASE[v] + (i % V_PER[v])));
      idle(30);
      check($sformatf("R3 R4 R5 R7 pattern %0d", v), int'(dist_q), m_dist);
      if (v == 0) begin
        // R2: idle cycles with a busy address bus change nothing
        for (int k = 0; k < 50; k++) begin
          @(negedge clk);
          wr_addr = AW'(V_BASE[0] + k * 7);
        end
        check("R2 idle keeps estimate", int'(dist_q), m_dist);
      end
    end

    // R1: reset in mid-run restores the idle value
    for (int i = 0; i < 100; i++) wr(AW'('h0700));
    do_reset();
    check("R1 mid-run reset", int'(dist_q), MAXV);

    // R4: generator restarts from its seed, same stream gives same estimate
    for (int i = 0; i < MAXV; i++) wr(AW'('h0042 + (i % 2)));
    idle(30);
    check("R4 seeded restart", int'(dist_q), m_dist);

    finish_run();
  end
endmodule